// File: doc/BRIEF.md
# Transmit Packet FIFO with Cut-Through Start

This block holds outgoing packets between a host that writes 32-bit words and a MAC transmit engine that takes them through a valid/ready handshake. The host marks the first and last word of each packet. The last word also carries the number of valid bytes it holds. The block counts the whole packets it contains. It withdraws its write-ready when the storage is full, and also when that count reaches a fixed limit.

A packet is offered to the transmit side once its last word has been stored. It is offered sooner if the bytes written so far for the packet still being written reach a threshold that can be changed while the block runs. A high threshold keeps more data in hand before sending and lowers the risk of running dry. A low threshold shortens the wait for long packets. Packets longer than the storage pass through in cut-through fashion.

If the engine asks for a word after a packet has begun and no data is left, an underflow flag is set. If the host writes while ready is low, the word is dropped and an overflow flag is set. Both flags stay set until a clear pulse.

Top module: `txPktFifo`

## Requirements
- R1: wrReady is low whenever 64 words (DEPTH) are stored.
- R2: wrReady is low whenever pktCount equals MAX_PKTS (default 2).
- R3: Once the last word (wrEop=1) of the head packet is stored, txValid is high, whatever the threshold.
- R4: While no whole packet is stored, txValid rises only when the bytes written for the open packet (4 per word without wrEop) are at least txThreshold. Until then txValid stays low.
- R5: pktCount rises by one when a word with wrEop=1 is accepted. It falls by one when a word with txEop=1 is taken. It is unchanged when both happen in the same cycle.
- R6: txThreshold may change at any time, and a new value acts in the same cycle.
- R7: A packet longer than the 64-word storage is sent in full, in cut-through mode, once the threshold is met.
- R8: If txReady is high while txValid is low after a started packet's first word (with txEop=0) has been taken and before its last word is taken, underflow is set. It holds until flagClr.
- R9: A write while wrReady is low is dropped: it never appears on the transmit side. It sets overflow, which holds until flagClr.
- R10: After reset the block is empty: pktCount=0, txValid=0, wrReady=1, and both flags are 0.
- R11: Words leave in write order, carrying their data, start marker, end marker and byte count (1 to 4, valid on the end word) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write strobe |
| wrReady | output | 1 | Host may write |
| wrData | input | 32 | Write data word |
| wrSop | input | 1 | First word of a packet |
| wrEop | input | 1 | Last word of a packet |
| wrBytes | input | 3 | Valid bytes in the last word (1..4) |
| txThreshold | input | 16 | Cut-through start level in bytes |
| txValid | output | 1 | A word is offered to the transmit engine |
| txReady | input | 1 | Transmit engine takes or wants a word |
| txData | output | 32 | Offered data word |
| txSop | output | 1 | Offered word is first of a packet |
| txEop | output | 1 | Offered word is last of a packet |
| txBytes | output | 3 | Valid bytes of the offered word |
| pktCount | output | 2 | Whole packets held |
| underflow | output | 1 | Sticky underrun flag |
| overflow | output | 1 | Sticky dropped-write flag |
| flagClr | input | 1 | Clears both sticky flags |

## Verification
If the packet counter drifts, the fault shows at wrReady and txValid in the cycle after the wrong update. A count that is too high withdraws ready early, or offers a packet whose end word is missing. A count that is too low lets the host pass the limit. If the open-packet byte counter is wrong, txValid rises one word too early or too late in the threshold sweep. If a pointer goes wrong, the next word out has the wrong data or markers, and the stream comparison catches it on that word. A wrong "packet started" state shows as an underflow flag that appears or fails to appear one cycle after the engine finds the FIFO empty.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/txpf_datapath.sv
module txpf_datapath import txpf_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int BYTES_W = 3,
  parameter int DEPTH   = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrSop,
  input  logic               wrEop,
  input  logic [BYTES_W-1:0] wrBytes,
  output logic               full,
  output logic               empty,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdSop,
  output logic               rdEop,
  output logic [BYTES_W-1:0] rdBytes
);
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int ENTRY_W = DATA_W + BYTES_W + 2;

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [ADDR_W:0]    wrPtr, rdPtr;
  logic [ENTRY_W-1:0] headEntry;

  // Pointers carry one extra wrap bit to tell full from empty.
  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[ADDR_W] != rdPtr[ADDR_W]) &&
                 (wrPtr[ADDR_W-1:0] == rdPtr[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr[ADDR_W-1:0]] <= {wrSop, wrEop, wrBytes, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign headEntry = store[rdPtr[ADDR_W-1:0]];
  assign rdSop     = headEntry[ENTRY_W-1];
  assign rdEop     = headEntry[ENTRY_W-2];
  assign rdBytes   = headEntry[DATA_W +: BYTES_W];
  assign rdData    = headEntry[DATA_W-1:0];
endmodule

// File: rtl/txpf_control.sv
module txpf_control import txpf_pkg::*; #(
  parameter int MAX_PKTS   = 2,
  parameter int CNT_W      = 2,
  parameter int THR_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrEop,
  input  logic             full,
  input  logic             empty,
  input  logic             headEop,
  input  logic             txReady,
  input  logic             flagClr,
  input  logic [THR_W-1:0] txThreshold,
  output fifoStrobe_t      strobe,
  output logic             wrReady,
  output logic             txValid,
  output logic [CNT_W-1:0] pktCount,
  output logic             underflow,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_PKTS);
  localparam logic [THR_W-1:0] BYTE_STEP = THR_W'(WORD_BYTES);
  localparam logic [THR_W-1:0] BYTE_SAT  = '1;

  logic             accept, popNow, startOk, sending, underRun;
  logic [THR_W-1:0] openBytes;

  assign wrReady  = !full && (pktCount < CNT_MAX);
  assign accept   = wrValid && wrReady;
  // A whole packet at the head, or enough of the open one, permits a start.
  assign startOk  = (pktCount != '0) || (openBytes >= txThreshold);
  assign txValid  = !empty && (sending || startOk);
  assign popNow   = txValid && txReady;
  assign underRun = sending && empty && txReady;

  assign strobe.push = accept;
  assign strobe.pop  = popNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktCount  <= '0;
      openBytes <= '0;
      sending   <= 1'b0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      case ({accept && wrEop, popNow && headEop})
        2'b10:   pktCount <= pktCount + 1'b1;
        2'b01:   pktCount <= pktCount - 1'b1;
        default: pktCount <= pktCount;
      endcase
      if (accept) begin
        if (wrEop)                              openBytes <= '0;
        else if (openBytes > BYTE_SAT - BYTE_STEP) openBytes <= BYTE_SAT;
        else                                    openBytes <= openBytes + BYTE_STEP;
      end
      if (popNow) sending <= !headEop;
      underflow <= (underflow && !flagClr) || underRun;
      overflow  <= (overflow && !flagClr) || (wrValid && !wrReady);
    end
  end
endmodule

// File: rtl/txPktFifo.sv
module txPktFifo import txpf_pkg::*; #(
  parameter  int DATA_W   = 32,
  parameter  int DEPTH    = 64,
  parameter  int MAX_PKTS = 2,
  parameter  int THR_W    = 16,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int BYTES_W  = $clog2(WORD_BYTES) + 1,
  localparam int CNT_W    = $clog2(MAX_PKTS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  output logic               wrReady,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrSop,
  input  logic               wrEop,
  input  logic [BYTES_W-1:0] wrBytes,
  input  logic [THR_W-1:0]   txThreshold,
  output logic               txValid,
  input  logic               txReady,
  output logic [DATA_W-1:0]  txData,
  output logic               txSop,
  output logic               txEop,
  output logic [BYTES_W-1:0] txBytes,
  output logic [CNT_W-1:0]   pktCount,
  output logic               underflow,
  output logic               overflow,
  input  logic               flagClr
);
  fifoStrobe_t strobe;
  logic        full, empty;

  txpf_datapath #(.DATA_W(DATA_W), .BYTES_W(BYTES_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .wrSop(wrSop), .wrEop(wrEop), .wrBytes(wrBytes),
    .full(full), .empty(empty),
    .rdData(txData), .rdSop(txSop), .rdEop(txEop), .rdBytes(txBytes)
  );

  txpf_control #(.MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W), .THR_W(THR_W),
                 .WORD_BYTES(WORD_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrEop(wrEop),
    .full(full), .empty(empty), .headEop(txEop), .txReady(txReady),
    .flagClr(flagClr), .txThreshold(txThreshold), .strobe(strobe),
    .wrReady(wrReady), .txValid(txValid), .pktCount(pktCount),
    .underflow(underflow), .overflow(overflow)
  );
endmodule

// File: rtl/txpf_checker.sv
module txpf_checker #(
  parameter int MAX_PKTS = 2,
  parameter int CNT_W    = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             full,
  input logic             wrValid,
  input logic             wrReady,
  input logic             wrEop,
  input logic             txValid,
  input logic             txReady,
  input logic             txEop,
  input logic [CNT_W-1:0] pktCount,
  input logic             underflow,
  input logic             overflow,
  input logic             flagClr
);
  logic wrEnd, rdEnd;
  assign wrEnd = wrValid && wrReady && wrEop;
  assign rdEnd = txValid && txReady && txEop;

  p_ready_full_r1: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !wrReady);

  p_ready_limit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount == CNT_W'(MAX_PKTS)) |-> !wrReady);

  p_head_offered_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount != '0) |-> txValid);

  p_count_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnd && !rdEnd) |=> (pktCount == $past(pktCount) + CNT_W'(1)));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEnd && rdEnd) |=> $stable(pktCount));

  p_underflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !flagClr) |=> underflow);

  p_overflow_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> overflow);
endmodule

bind txPktFifo txpf_checker #(.MAX_PKTS(MAX_PKTS), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .full(full), .wrValid(wrValid), .wrReady(wrReady),
  .wrEop(wrEop), .txValid(txValid), .txReady(txReady), .txEop(txEop),
  .pktCount(pktCount), .underflow(underflow), .overflow(overflow),
  .flagClr(flagClr)
);

// File: tb/txPktFifo_test.sv
`timescale 1ns/1ps
module txPktFifo_test;
  logic        clk = 1'b0;
  logic        rstN, wrValid, wrReady, wrSop, wrEop, txValid, txReady;
  logic        txSop, txEop, underflow, overflow, flagClr;
  logic [31:0] wrData, txData;
  logic [2:0]  wrBytes, txBytes;
  logic [15:0] txThreshold;
  logic [1:0]  pktCount;

  int testsRun = 0, testsFailed = 0;
  logic [36:0] expQ[$];
  int popped;

  always #4 clk = ~clk;

  txPktFifo uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic putWord(input logic sop, input logic eop, input logic [31:0] d,
                         input logic [2:0] b);
    wrValid = 1'b1; wrSop = sop; wrEop = eop; wrData = d; wrBytes = b;
    #1;
    if (wrReady) expQ.push_back({sop, eop, b, d});
    cyc();
    wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0;
  endtask

  // Compare the offered word with the model and count it when taken.
  task automatic takeIfValid();
    logic [36:0] e;
    if (txValid) begin
      if (expQ.size() == 0) chk("R11 unexpected word", 1, 0);
      else begin
        e = expQ.pop_front();
        chk("R11 word", int'({txSop, txEop, txBytes, txData} == e), 1);
      end
      popped++;
    end
  endtask

  task automatic drainAll();
    for (int i = 0; i < 400 && expQ.size() > 0; i++) begin
      txReady = 1'b1;
      #1;
      takeIfValid();
      cyc();
    end
    txReady = 1'b0;
    #1;
    chk("R11 queue drained", expQ.size(), 0);
  endtask

  initial begin
    #(200000 * 8);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrSop = 1'b0; wrEop = 1'b0; wrData = '0;
    wrBytes = 3'd4; txReady = 1'b0; flagClr = 1'b0; txThreshold = 16'hFFFF;
    repeat (3) cyc();
    rstN = 1'b1;
    #1;
    // R10 reset state
    chk("R10 pktCount", pktCount, 0);
    chk("R10 txValid", txValid, 0);
    chk("R10 wrReady", wrReady, 1);
    chk("R10 underflow", underflow, 0);
    chk("R10 overflow", overflow, 0);

    // R4 threshold sweep: txValid rises once 4*words >= threshold.
    for (int thr = 0; thr <= 24; thr += 3) begin
      txThreshold = 16'(thr);
      for (int n = 1; n <= 8; n++) begin
        putWord(n == 1, 1'b0, 32'(thr * 256 + n), 3'd4);
        #1;
        chk("R4 cut-through start", txValid, int'(4 * n >= thr));
      end
      putWord(1'b0, 1'b1, 32'(thr * 256 + 99), 3'd2);
      #1;
      chk("R3 offered after end word", txValid, 1);
      chk("R5 count after end word", pktCount, 1);
      drainAll();
      chk("R5 count after drain", pktCount, 0);
    end

    // R3/R2/R9: store-and-forward with a high threshold.
    txThreshold = 16'hFFFF;
    putWord(1'b1, 1'b0, 32'hA0, 3'd4);
    putWord(1'b0, 1'b0, 32'hA1, 3'd4);
    #1;
    chk("R4 held below threshold", txValid, 0);
    putWord(1'b0, 1'b1, 32'hA2, 3'd3);
    #1;
    chk("R3 whole packet offered", txValid, 1);
    putWord(1'b1, 1'b1, 32'hB0, 3'd1);
    #1;
    chk("R2 count at limit", pktCount, 2);
    chk("R2 ready low at limit", wrReady, 0);
    putWord(1'b1, 1'b1, 32'hDEAD, 3'd4);
    #1;
    chk("R9 overflow set", overflow, 1);
    chk("R9 count unchanged", pktCount, 2);
    cyc();
    chk("R9 overflow sticky", overflow, 1);
    flagClr = 1'b1; cyc(); flagClr = 1'b0;
    #1;
    chk("R9 overflow cleared", overflow, 0);
    popped = 0;
    drainAll();
    chk("R9 dropped word absent", popped, 4);

    // R5 simultaneous end write and end read.
    putWord(1'b1, 1'b1, 32'hC0, 3'd4);
    putWord(1'b1, 1'b0, 32'hD0, 3'd4);
    #1;
    chk("R5 count before", pktCount, 1);
    wrValid = 1'b1; wrSop = 1'b0; wrEop = 1'b1; wrData = 32'hD1; wrBytes = 3'd2;
    txReady = 1'b1;
    #1;
    expQ.push_back({1'b0, 1'b1, 3'd2, 32'hD1});
    takeIfValid();
    cyc();
    wrValid = 1'b0; wrEop = 1'b0; txReady = 1'b0;
    #1;
    chk("R5 count same-cycle", pktCount, 1);
    drainAll();
    chk("R5 count empty", pktCount, 0);

    // R1 fill the storage with one open packet.
    txThreshold = 16'hFFFF;
    for (int n = 0; n < 64; n++) begin
      #1;
      if (!wrReady) chk("R1 ready before full", wrReady, 1);
      putWord(n == 0, 1'b0, 32'(1000 + n), 3'd4);
    end
    #1;
    chk("R1 ready low when full", wrReady, 0);
    chk("R1 no whole packet", pktCount, 0);
    chk("R4 open packet held", txValid, 0);
    // R6 runtime threshold change acts at once (64 words = 256 bytes).
    txThreshold = 16'd257;
    #1;
    chk("R6 threshold above fill", txValid, 0);
    txThreshold = 16'd256;
    #1;
    chk("R6 threshold at fill", txValid, 1);

    // R7 jumbo packet: keep writing while streaming out.
    popped = 0;
    for (int n = 64, i = 0; i < 1000 && (n <= 200 || expQ.size() > 0); i++) begin
      txReady = 1'b1;
      #1;
      if (n <= 200 && wrReady) begin
        wrValid = 1'b1; wrSop = 1'b0; wrEop = (n == 200); wrData = 32'(1000 + n);
        wrBytes = (n == 200) ? 3'd1 : 3'd4;
        expQ.push_back({1'b0, wrEop, wrBytes, wrData});
        n++;
      end
      #1;
      takeIfValid();
      cyc();
      wrValid = 1'b0; wrEop = 1'b0;
    end
    txReady = 1'b0;
    #1;
    chk("R7 jumbo word count", popped, 201);
    chk("R7 no underflow", underflow, 0);
    chk("R7 no overflow", overflow, 0);
    chk("R7 count after jumbo", pktCount, 0);

    // R8 underflow after a cut-through start runs dry.
    txThreshold = 16'd4;
    putWord(1'b1, 1'b0, 32'hE0, 3'd4);
    putWord(1'b0, 1'b0, 32'hE1, 3'd4);
    for (int i = 0; i < 2; i++) begin
      txReady = 1'b1;
      #1;
      takeIfValid();
      cyc();
    end
    #1;
    chk("R8 no underflow yet", underflow, 0);
    cyc();
    txReady = 1'b0;
    #1;
    chk("R8 underflow set", underflow, 1);
    cyc();
    chk("R8 underflow sticky", underflow, 1);
    flagClr = 1'b1; cyc(); flagClr = 1'b0;
    #1;
    chk("R8 underflow cleared", underflow, 0);
    putWord(1'b0, 1'b1, 32'hE2, 3'd3);
    drainAll();
    chk("R8 count after finish", pktCount, 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule